// File: doc/BRIEF.md
# Dual-Width Transmit Word Serializer

This block takes already-encoded 10-bit transmit code words from a protocol device and turns them into a single serial bit stream, least significant code bit first. It runs entirely in one clock domain at the serial bit rate. A divide-by-ten phase counter stands in for the word-rate reference clock. The counter gives the protocol device a word-rate clock and two one-cycle strobes that mark where that clock's rising and falling edges fall.

Two capture widths are supported. In the full-width mode the device presents a whole code word once per word period, at the rising strobe. In the half-width double-edge mode only the five low data lines carry data. The half presented at the rising strobe supplies code bits 0 to 4, and the half at the falling strobe supplies bits 5 to 9. The block joins the halves into one word. The half-width path carries one extra word stage, so the two modes have different latencies that are fixed and known. A new word enters the shift register only in the cycle after the previous word's last bit has left it, so back-to-back words flow with no gap, no dropped bit and no repeated bit.

Top module: `tx_word_serializer`

## Requirements
- R1: While the synchronous reset is high and in the first cycle after it falls, serOut is low and the phase counter is at phase 0 (wordRise high).
- R2: wordRise is high in exactly one cycle of every ten, at phase 0. wordFall is high only at phase 5. refClk is high for phases 0 to 4 and low for phases 5 to 9.
- R3: With modeSel low (the full-width mode, the default), the word on txData[9:0] in a wordRise cycle is the word that is transmitted. Values present in other cycles have no effect.
- R4: Each word is sent bit 0 first and bit 9 last, one bit per clock, in ten consecutive cycles.
- R5: With modeSel high, txData[4:0] in a wordRise cycle becomes code bits 0 to 4, and txData[4:0] in the following wordFall cycle becomes code bits 5 to 9.
- R6: With modeSel high, txData[9:5] has no effect on the serial stream, and txData[4:0] outside the two strobe cycles has no effect.
- R7: In the full-width mode, a word captured in cycle c shows bit 0 on serOut in cycle c+10 and bit 9 in cycle c+19 (19 to 20 bit times from load to bit 9).
- R8: In the half-width mode, a word whose low half is captured in cycle c shows bit 0 in cycle c+20 and bit 9 in cycle c+29 (29 to 30 bit times).
- R9: A new word is loaded into the shift register only in the phase-9 cycle, so consecutive words follow one another with no idle, dropped or repeated bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | 0: full-width word capture; 1: half-width double-edge capture |
| txData | input | 10 | Encoded transmit data; only bits 4:0 are used in half-width mode |
| refClk | output | 1 | Word-rate clock derived from the phase counter |
| wordRise | output | 1 | One-cycle strobe at the rising edge of the word clock |
| wordFall | output | 1 | One-cycle strobe at the falling edge of the word clock |
| serOut | output | 1 | Serial data out, code bit 0 first |

## Verification
Both modes are driven with random code words in back-to-back periods, while random junk sits on the data lines in every cycle that carries no strobe. This separates capture at the correct strobe from capture in any other cycle. In the half-width mode random values on the upper five lines show whether those lines leak into the word. Directed patterns add alternating all-ones and all-zeros words, which expose a dropped or repeated bit at word boundaries, and a walking single one, which exposes bit-order or half-swap errors. Comma-like words are also sent. The serial stream is compared cycle by cycle against a schedule computed from the capture cycle and the mode latency, so a latency off by one cycle in either mode shows up directly.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  // Strobes passed from the phase control to the datapath
  typedef struct packed {
    logic riseCap;    // word-clock rising edge: full word or low half
    logic fallCap;    // word-clock falling edge: high half
    logic loadShift;  // last bit leaving: load next word
  } ser_ctrl_t;
endpackage

// File: rtl/tx_ser_ctrl.sv
module tx_ser_ctrl
  import tx_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic      clk,
  input  logic      rst,
  output ser_ctrl_t ctrl,
  output logic      refClk,
  output logic      wordRise,
  output logic      wordFall
);
  localparam int PH_W = $clog2(WORD_W);
  localparam int HALF = WORD_W / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                 phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  always_comb begin
    ctrl.riseCap   = (phase == '0);
    ctrl.fallCap   = (phase == PH_HALF);
    ctrl.loadShift = (phase == PH_LAST);
    refClk         = (phase < PH_HALF);
    wordRise       = ctrl.riseCap;
    wordFall       = ctrl.fallCap;
  end
endmodule

// File: rtl/tx_ser_dp.sv
module tx_ser_dp
  import tx_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic [WORD_W-1:0] txData,
  input  ser_ctrl_t         ctrl,
  output logic              serOut,
  output logic [WORD_W-1:0] shiftWord
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] capWord;   // full-width capture
  logic [HALF-1:0]   loHalf;    // half-width: rising-edge half
  logic [WORD_W-1:0] asmWord;   // half-width: assembled word
  logic [WORD_W-1:0] holdWord;  // half-width: extra word stage
  logic [WORD_W-1:0] nextWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      capWord <= '0;
      loHalf  <= '0;
    end else if (ctrl.riseCap) begin
      capWord <= txData;
      loHalf  <= txData[HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               asmWord <= '0;
    else if (ctrl.fallCap) asmWord <= {txData[WORD_W-HALF-1:0], loHalf};
  end

  always_ff @(posedge clk) begin
    if (rst)                 holdWord <= '0;
    else if (ctrl.loadShift) holdWord <= asmWord;
  end

  always_comb nextWord = modeSel ? holdWord : capWord;

  always_ff @(posedge clk) begin
    if (rst)                 shiftWord <= '0;
    else if (ctrl.loadShift) shiftWord <= nextWord;
    else                     shiftWord <= shiftWord >> 1;
  end

  always_comb serOut = shiftWord[0];
endmodule

// File: rtl/tx_word_serializer.sv
module tx_word_serializer
  import tx_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic [WORD_W-1:0] txData,
  output logic              refClk,
  output logic              wordRise,
  output logic              wordFall,
  output logic              serOut
);
  ser_ctrl_t         ctrl;
  logic [WORD_W-1:0] shiftWord;

  tx_ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .refClk   (refClk),
    .wordRise (wordRise),
    .wordFall (wordFall)
  );

  tx_ser_dp #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .modeSel   (modeSel),
    .txData    (txData),
    .ctrl      (ctrl),
    .serOut    (serOut),
    .shiftWord (shiftWord)
  );
endmodule

// File: rtl/tx_ser_chk.sv
module tx_ser_chk
  import tx_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              refClk,
  input logic              wordRise,
  input logic              wordFall,
  input logic              serOut,
  input ser_ctrl_t         ctrl,
  input logic [WORD_W-1:0] shiftWord
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!serOut && wordRise));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(wordRise && wordFall));

  p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
    wordRise |=> !wordRise);

  p_clk_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(refClk) |-> wordRise);

  p_clk_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(refClk) |-> wordFall);

  p_shift_order_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.loadShift)) |-> (shiftWord == ($past(shiftWord) >> 1)));

  p_load_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadShift |=> wordRise);
endmodule

bind tx_word_serializer tx_ser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .refClk    (refClk),
  .wordRise  (wordRise),
  .wordFall  (wordFall),
  .serOut    (serOut),
  .ctrl      (ctrl),
  .shiftWord (shiftWord)
);

// File: tb/tb_tx_word_serializer.sv
module tb_tx_word_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeSel = 1'b0;
  logic [9:0] txData = '0;
  logic       refClk, wordRise, wordFall, serOut;

  int checks = 0;
  int errors = 0;
  logic [9:0] words [64];

  always #2 clk = ~clk;  // 250 MHz

  tx_word_serializer dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .txData(txData),
    .refClk(refClk), .wordRise(wordRise), .wordFall(wordFall), .serOut(serOut)
  );

  task automatic chk(input string req, input int n, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, n, act, exp);
    end
  endtask

  // Expected serial bit in cycle n after reset release (R7, R8)
  function automatic logic expSer(input logic ddr, input int n);
    int lead = ddr ? 20 : 10;
    if (n < lead) return 1'b0;
    return words[(n - lead) / 10][(n - lead) % 10];
  endfunction

  task automatic fillWords(input int kind, input int nWords);
    for (int i = 0; i < 64; i++) begin
      if (i >= nWords)     words[i] = '0;
      else if (kind == 0)  words[i] = 10'($urandom);
      else if (kind == 1)  words[i] = (i % 2 == 0) ? 10'h3FF : 10'h000;
      else if (kind == 2)  words[i] = 10'(1 << (i % 10));
      else                 words[i] = (i % 2 == 0) ? 10'h17C : 10'h283;
    end
  endtask

  task automatic runMode(input logic ddr, input int kind, input int nWords, input string tag);
    int total = 10 * (nWords + 3);
    fillWords(kind, nWords);
    @(negedge clk);
    rst = 1'b1;
    modeSel = ddr;
    txData = 10'($urandom);
    @(negedge clk);
    @(negedge clk);
    chk("R1 serOut in reset", 0, serOut, 1'b0);
    rst = 1'b0;
    for (int n = 0; n < total; n++) begin
      int ph = n % 10;
      int k = n / 10;
      // sample outputs settled from the last rising edge
      chk("R2 wordRise", n, wordRise, ph == 0);
      chk("R2 wordFall", n, wordFall, ph == 5);
      chk("R2 refClk", n, refClk, ph < 5);
      if (n == 0) chk("R1 serOut after reset", n, serOut, 1'b0);
      chk(tag, n, serOut, expSer(ddr, n));
      // drive this cycle's data; junk where it must be ignored (R3, R6)
      txData = 10'($urandom);
      if (!ddr && ph == 0) txData = words[k];
      if (ddr && ph == 0)  txData[4:0] = words[k][4:0];
      if (ddr && ph == 5)  txData[4:0] = words[k][9:5];
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    runMode(1'b0, 0, 40, "R3 R4 R7 R9 full-width random");
    runMode(1'b0, 1, 12, "R4 R9 full-width alternating");
    runMode(1'b0, 2, 20, "R4 R7 full-width walking one");
    runMode(1'b1, 0, 40, "R5 R6 R8 R9 half-width random");
    runMode(1'b1, 1, 12, "R5 R9 half-width alternating");
    runMode(1'b1, 2, 20, "R5 R6 R8 half-width walking one");
    runMode(1'b1, 3, 10, "R5 R8 half-width comma words");
    runMode(1'b0, 3, 10, "R3 R7 full-width comma words");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule